// File: doc/BRIEF.md
# MDIO Management Bus Master

This block lets a processor reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. Software programs a small set of 32-bit registers (frame format, port and register or device address, outbound data), then writes a command word to launch one serial frame. While the frame is on the wire, a busy flag in the command word reads as 1. When the flag clears, the frame has finished and, for a read, the 16 returned bits can be read from the read-data register.

Two frame formats are supported, selected by one mode bit. The short-address format carries a 5-bit register number. The extended format addresses a 5-bit device number. Here a register access is two frames: an address frame that carries the 16-bit register address from the write-data register, then a separate read or write frame. The clock divider runs MDC continuously. Outbound bits change on the MDC falling edge and inbound bits are sampled on the rising edge. The MDIO pad is split into an output, an output enable and an input.

The engine is a state machine with states IDLE, SYNC, PREAMBLE, HEADER, TURN and DATA. The transitions are:
- IDLE→SYNC on an accepted command.
- SYNC→PREAMBLE on the next MDC fall.
- PREAMBLE→HEADER after bit 31.
- HEADER→TURN after bit 45.
- TURN→DATA after bit 47.
- DATA→IDLE on the MDC fall that ends bit 63.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads 0 and the busy flag is 0. MDC is 0, the MDIO output enable is 0 and the MDIO output is 1.
- R2: MDC runs freely with a period of 2*HALF_DIV system clocks. It first rises HALF_DIV clocks after reset is released.
- R3: The register map is as follows. Any bit not listed reads 0.
  - 0x40 holds the format bit at bit 8 (0 = short format, 1 = extended format).
  - 0x44 holds the port address at bits 12:8 and the register or device number at bits 4:0.
  - 0x48 holds the write data at bits 15:0.
  - 0x4C is the read data at bits 15:0. It is read-only, and writes to it have no effect.
  - 0x50 is the command. Writing bit 8 as 1 starts a frame, bits 1:0 are the operation code, and bit 16 reads back as busy.
- R4: A frame has 64 bits, sent MSB first. In order, these are: 32 preamble ones, a 2-bit start, a 2-bit opcode, the 5-bit port, the 5-bit register or device, a 2-bit turnaround and 16 data bits. The MDIO output changes only on a falling MDC edge.
- R5: In short format, start is 01. Code 0 is a read (opcode 10) and code 1 is a write (opcode 01).
- R6: In extended format, start is 00. Code 0 is an address frame (opcode 00), code 1 is a write (opcode 01) and code 2 is a read (opcode 11).
- R7: Write and address frames drive the turnaround as 1 then 0, followed by write-data bits 15:0.
- R8: Read frames release MDIO (output enable 0) from the first turnaround bit to the end of the frame. The 16 data bits are sampled on rising MDC edges and loaded into the read-data register in the same cycle that busy clears.
- R9: Busy reads 1 from the cycle after an accepted command until the frame ends. A command write while busy is 1 is ignored.
- R10: A command with bit 8 clear does not start a frame. Nor does an unsupported code: codes 2 and 3 in short format, or code 3 in extended format.
- R11: The frame contents are fixed when the command is accepted. Register writes during a frame do not change the bits sent.
- R12: While no frame is in progress, the MDIO output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest situation to reach from the ports is a command written while a frame is already in flight. This case has to show both that the command was dropped and that the frame on the wire was not disturbed. The stimulus launches a write frame and waits partway into it. It then rewrites the write-data register and issues a read command. The 64 captured bits must still match the original write frame, and once the frame ends busy must stay clear with MDIO released. Read frames are answered by a behavioural PHY that drives bits only after the master's turnaround. This exposes any mistake in which edge is sampled or in the count of captured bits.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } eng_state_t;

    localparam int FRAME_BITS = 64;
    localparam int PRE_LAST   = 31;
    localparam int HDR_LAST   = 45;
    localparam int TURN_LAST  = 47;

    localparam int OFS_MODE  = 'h40;
    localparam int OFS_ADDR  = 'h44;
    localparam int OFS_WDATA = 'h48;
    localparam int OFS_RDATA = 'h4C;
    localparam int OFS_CMD   = 'h50;

    localparam int MODE_EXT_BIT  = 8;
    localparam int CMD_START_BIT = 8;
    localparam int CMD_BUSY_BIT  = 16;

    typedef struct packed {
        logic       valid;
        logic       rd;
        logic [1:0] st;
        logic [1:0] op;
    } frame_ctl_t;

    function automatic frame_ctl_t decode_cmd(input logic ext, input logic [1:0] code);
        frame_ctl_t c;
        c = '0;
        if (!ext) begin
            c.st = 2'b01;
            unique case (code)
                2'd0: begin c.valid = 1'b1; c.rd = 1'b1; c.op = 2'b10; end
                2'd1: begin c.valid = 1'b1; c.op = 2'b01; end
                default: c.valid = 1'b0;
            endcase
        end else begin
            c.st = 2'b00;
            unique case (code)
                2'd0: begin c.valid = 1'b1; c.op = 2'b00; end
                2'd1: begin c.valid = 1'b1; c.op = 2'b01; end
                2'd2: begin c.valid = 1'b1; c.rd = 1'b1; c.op = 2'b11; end
                default: c.valid = 1'b0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap      = (div_cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            mdc     <= ~mdc;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic                  rd_frame,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  rd_load,
    output logic [15:0]           rd_data
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    eng_state_t state, nxt;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  rd_mode;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_SYNC;
            ST_SYNC:     if (fall_tick) nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_cnt == CNT_W'(PRE_LAST)) nxt = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_cnt == CNT_W'(HDR_LAST)) nxt = ST_TURN;
            ST_TURN:     if (fall_tick && bit_cnt == CNT_W'(TURN_LAST)) nxt = ST_DATA;
            ST_DATA:     if (fall_tick && bit_cnt == CNT_W'(FRAME_BITS - 1)) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '1;
            rd_mode <= 1'b0;
            rd_data <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                bit_cnt <= '0;
                shreg   <= frame_word;
                rd_mode <= rd_frame;
            end else if (fall_tick && state != ST_IDLE && state != ST_SYNC) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
            end
            if (rise_tick && state == ST_DATA)
                rd_data <= {rd_data[14:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        mdio_oe = 1'b0;
        unique case (state)
            ST_PREAMBLE, ST_HEADER: mdio_oe = 1'b1;
            ST_TURN, ST_DATA:       mdio_oe = !rd_mode;
            default:                mdio_oe = 1'b0;
        endcase
        mdio_o  = mdio_oe ? shreg[FRAME_BITS-1] : 1'b1;
        rd_load = rd_mode && fall_tick && state == ST_DATA &&
                  bit_cnt == CNT_W'(FRAME_BITS - 1);
    end

    // R4
    // mdio_change_on_fall_chk
    mdio_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $past(fall_tick));

    // R12
    // oe_rise_on_fall_chk
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> ($past(fall_tick) && busy));

    // R8
    // rd_load_ends_frame_chk
    rd_load_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> !busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 25,
    parameter int REG_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic        mode_ext;
    logic [4:0]  port_q, regn_q;
    logic [15:0] wdata_q, rdata_q;
    logic        rise_tick, fall_tick, busy, start, rd_load, cmd_wr;
    logic [15:0] rd_data;
    frame_ctl_t  ctl;
    logic [FRAME_BITS-1:0] frame_word;
    logic        wdata_unused;

    assign wdata_unused = ^reg_wdata[31:16];

    assign cmd_wr = reg_wr && reg_addr == REG_AW'(OFS_CMD);
    assign ctl    = decode_cmd(mode_ext, reg_wdata[1:0]);
    assign start  = cmd_wr && reg_wdata[CMD_START_BIT] && ctl.valid && !busy;
    assign frame_word = {32'hFFFF_FFFF, ctl.st, ctl.op, port_q, regn_q, 2'b10, wdata_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_ext <= 1'b0;
            port_q   <= '0;
            regn_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == REG_AW'(OFS_MODE)) mode_ext <= reg_wdata[MODE_EXT_BIT];
            if (reg_wr && reg_addr == REG_AW'(OFS_ADDR)) begin
                port_q <= reg_wdata[12:8];
                regn_q <= reg_wdata[4:0];
            end
            if (reg_wr && reg_addr == REG_AW'(OFS_WDATA)) wdata_q <= reg_wdata[15:0];
            if (rd_load) rdata_q <= rd_data;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_MODE)) reg_rdata[MODE_EXT_BIT] = mode_ext;
        if (reg_addr == REG_AW'(OFS_ADDR)) begin
            reg_rdata[12:8] = port_q;
            reg_rdata[4:0]  = regn_q;
        end
        if (reg_addr == REG_AW'(OFS_WDATA)) reg_rdata[15:0] = wdata_q;
        if (reg_addr == REG_AW'(OFS_RDATA)) reg_rdata[15:0] = rdata_q;
        if (reg_addr == REG_AW'(OFS_CMD))   reg_rdata[CMD_BUSY_BIT] = busy;
    end

    mdio_mgmt_clkdiv #(.HALF_DIV(HALF_DIV)) clkdiv_i (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_mgmt_engine engine_i (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_word(frame_word),
        .rd_frame(ctl.rd), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_load(rd_load), .rd_data(rd_data)
    );

    // R9
    // start_sets_busy_chk
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9
    // busy_only_from_start_chk
    busy_only_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr));

    // R10
    // bad_code_idle_chk
    bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !ctl.valid) |=> !busy);

    // R8
    // rdata_loaded_chk
    rdata_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (rdata_q == $past(rd_data)));

    // R2
    // mdc_rise_tick_chk
    mdc_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(rise_tick));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    localparam int HALF = 3;
    localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WD = 8'h48,
                           A_RD = 8'h4C, A_CMD = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    int cycles = 0;
    logic prev_mdc = 1'b0;
    logic prev_o = 1'b1;

    // frame capture / PHY model
    logic        arm = 1'b0;
    logic        capturing = 1'b0;
    logic        cap_done = 1'b0;
    int          idx = 0;
    logic [63:0] cap_o, cap_oe;
    logic        phy_read = 1'b0;
    logic [15:0] phy_ret = 16'h0;

    always #4 clk = ~clk;

    mdio_mgmt_master #(.HALF_DIV(HALF), .REG_AW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) if (rst_n) edges++;

    // per-clock reference comparison: MDC model and edge discipline of MDIO
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            logic exp_mdc;
            exp_mdc = ((edges / HALF) % 2) == 1;
            check(mdc === exp_mdc, "R2 mdc model", 64'(mdc), 64'(exp_mdc));
            if (mdio_o !== prev_o)
                check(prev_mdc == 1'b1 && mdc == 1'b0, "R4 mdio change off MDC fall",
                      64'(mdc), 64'(0));
            if (!arm && !capturing && !dut_i.busy) begin end
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    always @(posedge mdc) begin
        if (arm && !capturing && mdio_oe) begin
            capturing = 1'b1;
            idx = 0;
        end
        if (capturing) begin
            cap_o[63-idx]  = mdio_o;
            cap_oe[63-idx] = mdio_oe;
            if (phy_read && idx >= 47 && idx <= 62) mdio_i <= phy_ret[15-(idx-47)];
            if (idx == 63) mdio_i <= 1'b1;
            idx++;
            if (idx == 64) begin
                capturing = 1'b0;
                arm = 1'b0;
                cap_done = 1'b1;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [63:0] expect_word(input logic ext, input logic [1:0] code,
        input logic [4:0] port, input logic [4:0] regn, input logic [15:0] data);
        logic [1:0] st, op;
        st = ext ? 2'b00 : 2'b01;
        if (!ext) op = (code == 2'd0) ? 2'b10 : 2'b01;
        else      op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
        return {32'hFFFF_FFFF, st, op, port, regn, 2'b10, data};
    endfunction

    task automatic launch(input logic [1:0] code, input logic is_read, input logic [15:0] ret);
        phy_read = is_read;
        phy_ret  = ret;
        cap_done = 1'b0;
        arm      = 1'b1;
        wr(A_CMD, 32'h100 | 32'(code));
    endtask

    task automatic finish_frame(input logic [63:0] exp, input logic is_read, input string tag);
        logic [31:0] d;
        logic [63:0] oe_mask;
        wait (cap_done);
        d = 32'h0001_0000;
        for (int n = 0; n < 200 && d[16]; n++) rd(A_CMD, d);
        check(d[16] == 1'b0, {tag, " busy clears"}, 64'(d), 64'h0);
        oe_mask = is_read ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        check(cap_oe == oe_mask, {tag, " output enable pattern"}, cap_oe, oe_mask);
        check((cap_o & oe_mask) == (exp & oe_mask), {tag, " frame bits"},
              cap_o & oe_mask, exp & oe_mask);
    endtask

    initial begin
        logic [31:0] d;
        logic [63:0] e;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 pins in reset",
              {61'h0, mdc, mdio_oe, mdio_o}, 64'h1);
        rst_n = 1'b1;
        rd(A_MODE, d);  check(d == 0, "R1 mode reset", 64'(d), 0);
        rd(A_ADDR, d);  check(d == 0, "R1 addr reset", 64'(d), 0);
        rd(A_WD, d);    check(d == 0, "R1 wdata reset", 64'(d), 0);
        rd(A_RD, d);    check(d == 0, "R1 rdata reset", 64'(d), 0);
        rd(A_CMD, d);   check(d == 0, "R1 busy reset", 64'(d), 0);
        check(mdio_oe == 1'b0, "R12 idle released", 64'(mdio_oe), 0);

        // R3 register map
        wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, d); check(d == 32'h100, "R3 mode bits", 64'(d), 64'h100);
        wr(A_ADDR, 32'hFFFF_FFFF); rd(A_ADDR, d); check(d == 32'h1F1F, "R3 addr bits", 64'(d), 64'h1F1F);
        wr(A_WD, 32'hFFFF_FFFF);   rd(A_WD, d);   check(d == 32'hFFFF, "R3 wdata bits", 64'(d), 64'hFFFF);
        wr(A_RD, 32'hFFFF_FFFF);   rd(A_RD, d);   check(d == 32'h0, "R3 rdata read-only", 64'(d), 0);

        // R5 R7 short-format write
        wr(A_MODE, 32'h0); wr(A_ADDR, 32'h110A); wr(A_WD, 32'hBEEF);
        launch(2'd1, 1'b0, 16'h0);
        finish_frame(expect_word(1'b0, 2'd1, 5'h11, 5'h0A, 16'hBEEF), 1'b0, "R5 R7 short write");

        // R5 R8 short-format read
        wr(A_ADDR, 32'h0A13);
        launch(2'd0, 1'b1, 16'h1234);
        finish_frame(expect_word(1'b0, 2'd0, 5'h0A, 5'h13, 16'hBEEF), 1'b1, "R5 R8 short read");
        rd(A_RD, d); check(d == 32'h1234, "R8 read data short", 64'(d), 64'h1234);

        // R6 R7 extended address, write, read
        wr(A_MODE, 32'h100); wr(A_ADDR, 32'h031E); wr(A_WD, 32'h8001);
        launch(2'd0, 1'b0, 16'h0);
        finish_frame(expect_word(1'b1, 2'd0, 5'h03, 5'h1E, 16'h8001), 1'b0, "R6 R7 ext address");
        wr(A_WD, 32'h5A5A);
        launch(2'd1, 1'b0, 16'h0);
        finish_frame(expect_word(1'b1, 2'd1, 5'h03, 5'h1E, 16'h5A5A), 1'b0, "R6 ext write");
        launch(2'd2, 1'b1, 16'hC3A5);
        finish_frame(expect_word(1'b1, 2'd2, 5'h03, 5'h1E, 16'h5A5A), 1'b1, "R6 R8 ext read");
        rd(A_RD, d); check(d == 32'hC3A5, "R8 read data ext", 64'(d), 64'hC3A5);

        // R9 R11 busy and ignored command during a frame
        wr(A_MODE, 32'h0); wr(A_ADDR, 32'h0203); wr(A_WD, 32'h0F0F);
        e = expect_word(1'b0, 2'd1, 5'h02, 5'h03, 16'h0F0F);
        launch(2'd1, 1'b0, 16'h0);
        repeat (20) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b1, "R9 busy mid-frame", 64'(d), 64'h10000);
        wr(A_WD, 32'hFFFF);
        wr(A_ADDR, 32'h1F1F);
        wr(A_CMD, 32'h100);
        finish_frame(e, 1'b0, "R9 R11 frame unchanged");
        repeat (8 * HALF) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b0, "R9 ignored command left idle", 64'(d), 0);
        check(mdio_oe == 1'b0, "R12 released after frame", 64'(mdio_oe), 0);

        // R10 unsupported codes and missing start bit
        wr(A_CMD, 32'h102); repeat (2) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b0, "R10 short code 2", 64'(d), 0);
        wr(A_CMD, 32'h103); repeat (2) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b0, "R10 short code 3", 64'(d), 0);
        wr(A_CMD, 32'h001); repeat (2) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b0, "R10 start bit clear", 64'(d), 0);
        wr(A_MODE, 32'h100);
        wr(A_CMD, 32'h103); repeat (4 * HALF) @(negedge clk);
        rd(A_CMD, d); check(d[16] == 1'b0, "R10 ext code 3", 64'(d), 0);
        check(mdio_oe == 1'b0, "R10 R12 bus stays released", 64'(mdio_oe), 0);

        summary();
    end
endmodule